// File: doc/BRIEF.md
# Vertex Buffer Rate Equalizer

This block decouples a processor that produces vertex data as 32-bit words on a fast clock from a rendering engine that consumes it as 128-bit words on a clock four times slower. The 1 kB of storage is dual-ported: one port sits in the processor clock domain and the other in the rendering clock domain. Four processor words are gathered into one rendering word. The write and read positions cross between the domains as Gray-coded counts through two-flop synchronizers.

The storage is built from four banks of 256 bytes. A 2-bit size setting chooses how many banks the FIFO uses, and the banks outside that size are switched off to save power. A mode bit turns the whole memory into a directly addressed scratchpad that the processor reads and writes. The size and the mode can only be changed while the FIFO holds nothing.

Top module: `vtx_rate_eq`

## Requirements
- R1: Four accepted processor writes form one 128-bit read word. The first write goes to bits [31:0], the second to [63:32], the third to [95:64] and the fourth to [127:96]. The read side is first-word-fall-through: `r_data_o` holds the oldest word while `r_empty_o` is low, and `r_rd_i` removes that word.
- R2: Read words come out in write order. The FIFO wraps after 16*(size+1) entries, where size is the 2-bit setting, so its capacity is 64*(size+1) processor words.
- R3: `w_full_o` is high exactly while 16*(size+1) complete entries are held. `w_empty_o` is high while no complete entry and no partial entry is held. `r_empty_o` goes low once a complete entry reaches the read side.
- R4: In FIFO mode, a write while `w_full_o` is high is dropped and sets `w_overflow_o`, which stays high until reset.
- R5: A read strobe while `r_empty_o` is high removes nothing and sets `r_underflow_o`, which stays high until reset.
- R6: In FIFO mode, `bank_en_o[i]` is high exactly when i <= size, so size values 0 to 3 enable 1 to 4 banks starting from bit 0.
- R7: A `cfg_we_i` request loads `cfg_size_i` and `cfg_mode_i` only in a cycle where `w_empty_o` is high and `cpu_wr_i` is low. In any other cycle the request is ignored, and `bank_en_o` and the mode stay as they were.
- R8: In scratchpad mode (`cfg_mode_i`=1), all four bits of `bank_en_o` are high. `cpu_wr_i` stores `cpu_wdata_i` at word address `cpu_addr_i`, where bits [7:6] select the bank. `cpu_rd_i` returns the stored word on `cpu_rdata_o` after one processor clock. These accesses leave `w_empty_o` and `r_empty_o` high.
- R9: After reset the size is 0 and the mode is FIFO. `bank_en_o` is 0001, both empty flags are high, and `w_full_o` and both sticky flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Processor-side clock |
| rclk_i | input | 1 | Rendering-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| cfg_we_i | input | 1 | Request to load size and mode |
| cfg_size_i | input | 2 | Active banks minus one |
| cfg_mode_i | input | 1 | 0 FIFO, 1 scratchpad |
| cpu_wr_i | input | 1 | Processor write strobe |
| cpu_rd_i | input | 1 | Scratchpad read strobe |
| cpu_addr_i | input | 8 | Scratchpad word address |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_rdata_o | output | 32 | Scratchpad read data |
| w_full_o | output | 1 | FIFO full, processor domain |
| w_empty_o | output | 1 | FIFO empty, processor domain |
| w_overflow_o | output | 1 | Sticky dropped-write flag |
| bank_en_o | output | 4 | Per-bank enables |
| r_rd_i | input | 1 | Rendering-side read strobe |
| r_data_o | output | 128 | Oldest rendering word |
| r_empty_o | output | 1 | Nothing to read, rendering domain |
| r_underflow_o | output | 1 | Sticky empty-read flag |

## Verification
Two pairs of events can land in the same cycle. A configuration request can arrive together with the write that fills the first lane of an empty FIFO. The bench drives `cfg_we_i` and `cpu_wr_i` on the same edge and expects the write to be taken, `w_empty_o` to fall and `bank_en_o` to stay unchanged. The read side can also remove the last held entry in the cycle that a new entry's count arrives. Continuous streaming with the reader always draining provokes this, and a scoreboard judges it: the scoreboard pops a packed word for every read and compares it, so any lost, repeated or reordered entry shows up across many wraps at several sizes.

// File: rtl/vbeq_pkg.sv
package vbeq_pkg;
  typedef enum logic {MODE_FIFO = 1'b0, MODE_SCRATCH = 1'b1} buf_mode_e;
endpackage

// File: rtl/vbeq_sync.sv
module vbeq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/vbeq_bank.sv
// One bank: lane-wide read/write port A on the processor clock,
// line-wide combinational read port B for the rendering side.
module vbeq_bank #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned ROWS   = 16
) (
  input  logic                        a_clk_i,
  input  logic                        en_i,
  input  logic                        a_we_i,
  input  logic [$clog2(ROWS)-1:0]     a_row_i,
  input  logic [$clog2(LANES)-1:0]    a_lane_i,
  input  logic [WORD_W-1:0]           a_wdata_i,
  output logic [WORD_W-1:0]           a_rdata_o,
  input  logic [$clog2(ROWS)-1:0]     b_row_i,
  output logic [LANES*WORD_W-1:0]     b_rdata_o
);
  logic [WORD_W-1:0] mem_q [ROWS][LANES];

  always_ff @(posedge a_clk_i) begin
    if (en_i && a_we_i) mem_q[a_row_i][a_lane_i] <= a_wdata_i;
  end

  assign a_rdata_o = en_i ? mem_q[a_row_i][a_lane_i] : '0;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      b_rdata_o[l*WORD_W +: WORD_W] = en_i ? mem_q[b_row_i][l] : '0;
    end
  end
endmodule

// File: rtl/vtx_rate_eq.sv
module vtx_rate_eq
  import vbeq_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LANES      = 4,
  parameter int unsigned BANKS      = 4,
  parameter int unsigned BANK_WORDS = 64
) (
  input  logic                                  wclk_i,
  input  logic                                  rclk_i,
  input  logic                                  rst_ni,
  input  logic                                  cfg_we_i,
  input  logic [$clog2(BANKS)-1:0]              cfg_size_i,
  input  logic                                  cfg_mode_i,
  input  logic                                  cpu_wr_i,
  input  logic                                  cpu_rd_i,
  input  logic [$clog2(BANKS*BANK_WORDS)-1:0]   cpu_addr_i,
  input  logic [WORD_W-1:0]                     cpu_wdata_i,
  output logic [WORD_W-1:0]                     cpu_rdata_o,
  output logic                                  w_full_o,
  output logic                                  w_empty_o,
  output logic                                  w_overflow_o,
  output logic [BANKS-1:0]                      bank_en_o,
  input  logic                                  r_rd_i,
  output logic [LANES*WORD_W-1:0]               r_data_o,
  output logic                                  r_empty_o,
  output logic                                  r_underflow_o
);
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned EPB    = BANK_WORDS / LANES;   // entries per bank
  localparam int unsigned EB_W   = $clog2(EPB);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned ENT_W  = EB_W + BANK_W;
  localparam int unsigned CNT_W  = ENT_W + 1;
  localparam int unsigned ADDR_W = ENT_W + LANE_W;
  localparam int unsigned LINE_W = LANES * WORD_W;

  function automatic logic [CNT_W-1:0] g2b(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    for (int i = 0; i < CNT_W; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  function automatic logic [CNT_W-1:0] b2g(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- processor domain ----------------
  logic [BANK_W-1:0] size_q;
  buf_mode_e         mode_q;
  logic [LANE_W-1:0] lane_q;
  logic [ENT_W-1:0]  waddr_q;
  logic [CNT_W-1:0]  wcnt_q, wgray_q, rgray_w, rcnt_w, occ_w, cap_w, wcnt_nx;
  logic              ovf_q;
  logic [WORD_W-1:0] rdata_q;
  logic              fifo_wr, push, sp_wr, sp_rd, cfg_ok, w_full, w_empty, lane_last, wlast;
  logic [ENT_W-1:0]  a_ent;
  logic [LANE_W-1:0] a_lane;
  logic [BANK_W-1:0] a_bank;
  logic              a_we;
  logic [WORD_W-1:0] a_rdata [BANKS];
  logic [BANKS-1:0]  bank_en;

  vbeq_sync #(.W(CNT_W)) u_rptr_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_w)
  );

  always_comb begin
    rcnt_w    = g2b(rgray_w);
    occ_w     = wcnt_q - rcnt_w;
    cap_w     = CNT_W'((int'(size_q) + 1) * EPB);
    w_full    = (occ_w == cap_w);
    w_empty   = (occ_w == '0) && (lane_q == '0);
    fifo_wr   = cpu_wr_i && (mode_q == MODE_FIFO);
    push      = fifo_wr && !w_full;
    sp_wr     = cpu_wr_i && (mode_q == MODE_SCRATCH);
    sp_rd     = cpu_rd_i && (mode_q == MODE_SCRATCH);
    cfg_ok    = cfg_we_i && w_empty && !cpu_wr_i;   // a same-cycle write wins
    lane_last = (lane_q == LANE_W'(LANES - 1));
    wlast     = (waddr_q == ENT_W'(cap_w - CNT_W'(1)));
    wcnt_nx   = wcnt_q + CNT_W'(1);
    a_ent     = (mode_q == MODE_SCRATCH) ? cpu_addr_i[ADDR_W-1:LANE_W] : waddr_q;
    a_lane    = (mode_q == MODE_SCRATCH) ? cpu_addr_i[LANE_W-1:0] : lane_q;
    a_bank    = a_ent[ENT_W-1:EB_W];
    a_we      = push || sp_wr;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= '0;
      mode_q  <= MODE_FIFO;
      lane_q  <= '0;
      waddr_q <= '0;
      wcnt_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cfg_ok) begin
        size_q <= cfg_size_i;
        mode_q <= buf_mode_e'(cfg_mode_i);
        if (cfg_size_i != size_q) waddr_q <= '0;
      end
      if (push) begin
        lane_q <= lane_q + LANE_W'(1);
        if (lane_last) begin
          wcnt_q  <= wcnt_nx;
          wgray_q <= b2g(wcnt_nx);
          waddr_q <= wlast ? '0 : waddr_q + ENT_W'(1);
        end
      end
      if (fifo_wr && w_full) ovf_q <= 1'b1;
      if (sp_rd) rdata_q <= a_rdata[a_bank];
    end
  end

  // ---------------- rendering domain ----------------
  logic [CNT_W-1:0]  wgray_r, wcnt_r, rcnt_q, rgray_q, rcnt_nx, cap_r;
  logic [BANK_W-1:0] size_r, size_d_q;
  logic [ENT_W-1:0]  raddr_q;
  logic              udf_q, r_empty, pop, rlast;
  logic [LINE_W-1:0] b_rdata [BANKS];

  vbeq_sync #(.W(CNT_W)) u_wptr_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_r)
  );
  // size is quasi-static: it only moves while the FIFO is empty
  vbeq_sync #(.W(BANK_W)) u_size_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(size_q), .q_o(size_r)
  );

  always_comb begin
    wcnt_r  = g2b(wgray_r);
    r_empty = (rcnt_q == wcnt_r);
    pop     = r_rd_i && !r_empty;
    cap_r   = CNT_W'((int'(size_r) + 1) * EPB);
    rlast   = (raddr_q == ENT_W'(cap_r - CNT_W'(1)));
    rcnt_nx = rcnt_q + CNT_W'(1);
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_d_q <= '0;
      raddr_q  <= '0;
      rcnt_q   <= '0;
      rgray_q  <= '0;
      udf_q    <= 1'b0;
    end else begin
      size_d_q <= size_r;
      if (size_r != size_d_q) raddr_q <= '0;
      else if (pop) raddr_q <= rlast ? '0 : raddr_q + ENT_W'(1);
      if (pop) begin
        rcnt_q  <= rcnt_nx;
        rgray_q <= b2g(rcnt_nx);
      end
      if (r_rd_i && r_empty) udf_q <= 1'b1;
    end
  end

  // ---------------- banks ----------------
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign bank_en[g] = (mode_q == MODE_SCRATCH) || (BANK_W'(g) <= size_q);
    vbeq_bank #(.WORD_W(WORD_W), .LANES(LANES), .ROWS(EPB)) u_bank (
      .a_clk_i  (wclk_i),
      .en_i     (bank_en[g]),
      .a_we_i   (a_we && (a_bank == BANK_W'(g))),
      .a_row_i  (a_ent[EB_W-1:0]),
      .a_lane_i (a_lane),
      .a_wdata_i(cpu_wdata_i),
      .a_rdata_o(a_rdata[g]),
      .b_row_i  (raddr_q[EB_W-1:0]),
      .b_rdata_o(b_rdata[g])
    );
  end

  assign cpu_rdata_o   = rdata_q;
  assign w_full_o      = w_full;
  assign w_empty_o     = w_empty;
  assign w_overflow_o  = ovf_q;
  assign bank_en_o     = bank_en;
  assign r_data_o      = b_rdata[raddr_q[ENT_W-1:EB_W]];
  assign r_empty_o     = r_empty;
  assign r_underflow_o = udf_q;
endmodule

// File: rtl/vtx_rate_eq_chk.sv
module vtx_rate_eq_chk #(
  parameter int unsigned BANKS = 4
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             cpu_wr_i,
  input logic             r_rd_i,
  input logic             w_full_o,
  input logic             w_empty_o,
  input logic             w_overflow_o,
  input logic [BANKS-1:0] bank_en_o,
  input logic             r_empty_o,
  input logic             r_underflow_o
);
  a_r3_full_not_empty: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(w_full_o && w_empty_o));

  a_r4_ovf_sticky: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    w_overflow_o |=> w_overflow_o);

  a_r4_ovf_cause: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $rose(w_overflow_o) |-> $past(cpu_wr_i && w_full_o));

  a_r5_udf_set: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (r_rd_i && r_empty_o) |=> r_underflow_o);

  a_r5_udf_sticky: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    r_underflow_o |=> r_underflow_o);

  a_r7_cfg_held: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !w_empty_o |=> $stable(bank_en_o));
endmodule

bind vtx_rate_eq vtx_rate_eq_chk #(.BANKS(BANKS)) u_chk (.*);

// File: tb/sim_vtx_rate_eq.sv
`timescale 1ns/1ps
module sim_vtx_rate_eq;
  logic         wclk = 0, rclk = 0, rst_n = 0;
  logic         cfg_we = 0, cfg_mode = 0, cpu_wr = 0, cpu_rd = 0, r_rd = 0;
  logic [1:0]   cfg_size = 0;
  logic [7:0]   cpu_addr = 0;
  logic [31:0]  cpu_wdata = 0, cpu_rdata;
  logic         w_full, w_empty, w_ovf, r_empty, r_udf;
  logic [3:0]   bank_en;
  logic [127:0] r_data;
  int           n_chk = 0, n_err = 0;
  bit           mon_en = 1, force_rd = 0, done = 0;
  logic [127:0] sb_q [$];

  always #10 wclk = ~wclk;                 // 50 MHz processor clock
  initial begin #5; forever #40 rclk = ~rclk; end

  vtx_rate_eq u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_size_i(cfg_size), .cfg_mode_i(cfg_mode),
    .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .w_full_o(w_full), .w_empty_o(w_empty), .w_overflow_o(w_ovf),
    .bank_en_o(bank_en), .r_rd_i(r_rd), .r_data_o(r_data),
    .r_empty_o(r_empty), .r_underflow_o(r_udf)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every word the reader takes
  always @(negedge rclk) begin
    r_rd = 0;
    if (rst_n && mon_en && !r_empty) begin
      if (sb_q.size() == 0) chk(0, "R2 unexpected read word", r_data, 128'h0);
      else begin
        logic [127:0] e;
        e = sb_q.pop_front();
        chk(r_data == e, "R1/R2 packed word", r_data, e);
      end
      r_rd = 1;
    end
    if (force_rd) r_rd = 1;
  end

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge wclk);
    cpu_wr = 0;
  endtask

  function automatic logic [31:0] word_of(input int k, input int l);
    return {8'(k), 8'(l), 16'hBEEF ^ 16'(k * 5 + l)};
  endfunction

  task automatic push_entry(input int k, input bit gate);
    logic [127:0] e;
    for (int l = 0; l < 4; l++) begin
      if (gate) while (w_full) @(negedge wclk);
      wr_word(8'h00, word_of(k, l));
      e[l*32 +: 32] = word_of(k, l);
    end
    sb_q.push_back(e);
  endtask

  task automatic stream(input int n, input int start);
    for (int k = 0; k < n; k++) push_entry(start + k, 1);
  endtask

  task automatic drain();
    do @(negedge wclk); while (!(sb_q.size() == 0 && r_empty && w_empty));
    repeat (12) @(negedge wclk);
  endtask

  task automatic cfg_req(input bit m, input logic [1:0] s);
    cfg_mode = m; cfg_size = s; cfg_we = 1;
    @(negedge wclk);
    cfg_we = 0;
    repeat (16) @(negedge wclk);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge wclk);
    rst_n = 1;
    @(negedge wclk);
    // R9 reset state
    chk(bank_en == 4'b0001, "R9 bank_en", 128'(bank_en), 128'h1);
    chk(w_empty && r_empty, "R9 empties", {w_empty, r_empty}, 2'b11);
    chk(!w_full && !w_ovf && !r_udf, "R9 full/sticky", {w_full, w_ovf, r_udf}, 3'b000);

    // R5 read while empty
    @(posedge rclk); #1 force_rd = 1;
    @(posedge rclk); #1 force_rd = 0;
    chk(r_udf == 1, "R5 underflow set", 128'(r_udf), 128'h1);
    chk(r_empty == 1, "R5 nothing removed", 128'(r_empty), 128'h1);
    @(negedge wclk);

    // R1 R2 stream at size 0, wraps at 16 entries
    stream(40, 0);
    drain();
    chk(!w_ovf, "R2 no overflow in gated stream", 128'(w_ovf), 128'h0);

    // R6 size 1
    cfg_req(0, 2'd1);
    chk(bank_en == 4'b0011, "R6 size1 banks", 128'(bank_en), 128'h3);
    stream(70, 100);
    drain();

    // R3 R4 fill to 32 entries with reader paused
    mon_en = 0;
    for (int k = 0; k < 32; k++) push_entry(200 + k, 0);
    repeat (16) @(negedge wclk);
    chk(w_full == 1, "R3 full at 128 words", 128'(w_full), 128'h1);
    chk(r_empty == 0, "R3 read side sees data", 128'(r_empty), 128'h0);
    chk(w_ovf == 0, "R4 no overflow before extra", 128'(w_ovf), 128'h0);
    wr_word(8'h00, 32'hDEAD_BEEF);
    chk(w_ovf == 1, "R4 overflow set", 128'(w_ovf), 128'h1);
    chk(w_full == 1, "R4 still full", 128'(w_full), 128'h1);
    cfg_req(0, 2'd3);
    chk(bank_en == 4'b0011, "R7 cfg ignored when full", 128'(bank_en), 128'h3);
    mon_en = 1;
    drain();
    chk(!w_full && w_empty, "R3 empty after drain", {w_full, w_empty}, 2'b01);
    chk(w_ovf == 1, "R4 overflow sticky", 128'(w_ovf), 128'h1);

    // R7 partial entry blocks config
    wr_word(8'h00, word_of(300, 0));
    cfg_req(0, 2'd3);
    chk(bank_en == 4'b0011, "R7 cfg ignored with partial entry", 128'(bank_en), 128'h3);
    begin
      logic [127:0] e;
      e[31:0] = word_of(300, 0);
      for (int l = 1; l < 4; l++) begin
        wr_word(8'h00, word_of(300, l));
        e[l*32 +: 32] = word_of(300, l);
      end
      sb_q.push_back(e);
    end
    drain();

    // R7 config and write in the same cycle: write wins
    begin
      logic [127:0] e;
      cfg_mode = 0; cfg_size = 2'd3; cfg_we = 1;
      cpu_addr = 0; cpu_wdata = word_of(310, 0); cpu_wr = 1;
      @(negedge wclk);
      cfg_we = 0; cpu_wr = 0;
      chk(bank_en == 4'b0011, "R7 same-cycle cfg ignored", 128'(bank_en), 128'h3);
      chk(w_empty == 0, "R7 same-cycle write taken", 128'(w_empty), 128'h0);
      e[31:0] = word_of(310, 0);
      for (int l = 1; l < 4; l++) begin
        wr_word(8'h00, word_of(310, l));
        e[l*32 +: 32] = word_of(310, l);
      end
      sb_q.push_back(e);
    end
    drain();

    // R8 scratchpad
    cfg_req(1, 2'd1);
    chk(bank_en == 4'b1111, "R8 all banks on", 128'(bank_en), 128'hf);
    wr_word(8'hC5, 32'h1234_5678);
    wr_word(8'h03, 32'h0BAD_F00D);
    cpu_addr = 8'hC5; cpu_rd = 1; @(negedge wclk); cpu_rd = 0;
    chk(cpu_rdata == 32'h1234_5678, "R8 read bank3", 128'(cpu_rdata), 128'h1234_5678);
    cpu_addr = 8'h03; cpu_rd = 1; @(negedge wclk); cpu_rd = 0;
    chk(cpu_rdata == 32'h0BAD_F00D, "R8 read bank0", 128'(cpu_rdata), 128'h0BAD_F00D);
    repeat (16) @(negedge wclk);
    chk(w_empty && r_empty, "R8 FIFO untouched", {w_empty, r_empty}, 2'b11);

    // back to FIFO, size 0 then size 2 with wraps
    cfg_req(0, 2'd0);
    chk(bank_en == 4'b0001, "R6 size0 banks", 128'(bank_en), 128'h1);
    stream(20, 400);
    drain();
    cfg_req(0, 2'd2);
    chk(bank_en == 4'b0111, "R6 size2 banks", 128'(bank_en), 128'h7);
    stream(60, 500);
    drain();
    chk(w_ovf && r_udf, "R4/R5 flags still set", {w_ovf, r_udf}, 2'b11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule